// File: doc/BRIEF.md
# Three-Voice Oscillator Hard-Sync Ring

This block ties three phase-accumulator oscillators into a closed ring. Each voice takes its sync from one fixed neighbour. Each voice is also the sync source of one other voice. Every voice computes its own advanced accumulator value for the cycle outside this block, as accumulator plus frequency word, or zero while the voice is in test mode. The block receives the three advanced values together with each voice's test and sync-enable bits. It then decides which voices are hard-synced and registers the resulting accumulators. These registered values are fed back to the voices and their waveform shapers.

Sync is resolved only after all voices have advanced, so the voices behave as if they run in parallel. A destination voice is cleared when two conditions hold in the same cycle: the top bit of its source rises, and the destination has sync enabled. There is one exception. If the source is itself being synced in that same cycle, the sync does not pass on to the destination. The block also supplies each voice's ring-modulation MSB. This is the voice's own accumulator top bit XOR the top bit of its source.

Each voice has a small tracker state machine with three states:
- `PH_LOW`: the accumulator top bit is clear. This is the reset state.
- `PH_HIGH`: the top bit is set.
- `PH_HELD`: the voice is held in test mode.

The transitions are:
- `T_HOLD`: any state goes to `PH_HELD` while test is high.
- `T_SYNC`: any state goes to `PH_LOW` when the voice is cleared by sync.
- `T_RISE`: `PH_LOW` or `PH_HELD` goes to `PH_HIGH` when the advanced top bit is set.
- `T_WRAP`: any state goes to `PH_LOW` when the advanced top bit is clear.
- `T_STAY`: `PH_HIGH` stays in `PH_HIGH` while the advanced top bit stays set.

A rise is reported only from `PH_LOW` or `PH_HELD`.

Top module: `osc_sync_ring`

## Requirements
- R1: After reset, every `acc_o` lane is zero, every `ring_msb_o` bit is zero, and `msb_rise_o` is zero when the advanced inputs are zero.
- R2: A voice that is not in test mode and is not cleared by sync registers its `adv_acc_i` lane into `acc_o` on the next clock edge.
- R3: `msb_rise_o[v]` is high in the same cycle exactly when all three hold: `test_i[v]` is low, bit 23 of `acc_o[v]` is 0, and bit 23 of `adv_acc_i[v]` is 1.
- R4: While `test_i[v]` is high, `msb_rise_o[v]` stays low and `acc_o[v]` becomes zero on the next edge, whatever `adv_acc_i[v]` holds.
- R5: The source of voice v is voice (v+2) mod 3. That is, voice 0 takes sync from voice 2, voice 1 from voice 0, and voice 2 from voice 1.
- R6: When `msb_rise_o` of a voice's source is high and the voice's `sync_en_i` bit is 1, the voice's `acc_o` becomes zero on the next edge, subject to R7.
- R7: If the source has its own `sync_en_i` bit set and the source's own source rises in the same cycle, the destination is not cleared. It takes its `adv_acc_i` value instead.
- R8: `ring_msb_o[v]` equals bit 23 of `acc_o[v]` XOR bit 23 of `acc_o` of the source of v, with no added delay.
- R9: A voice whose `sync_en_i` bit is 0 is never cleared, even when its source rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_acc_i | input | 3x24 | Per-voice accumulator after this cycle's advance |
| test_i | input | 3 | Per-voice test mode (hold at zero) |
| sync_en_i | input | 3 | Per-voice hard-sync enable |
| acc_o | output | 3x24 | Registered post-sync accumulators |
| msb_rise_o | output | 3 | Per-voice top-bit rise in the current cycle |
| ring_msb_o | output | 3 | Per-voice ring-modulation MSB |

## Verification
The first pattern is three unrelated frequency words with sync off. It separates plain registration and rise detection from any sync effect. A single synced destination driven by a fast source shows the clearing and the fixed ring wiring. Two voices given equal frequencies from a common zero start make their top bits rise in the same cycle. This pattern separates the same-cycle exception from plain sync, because one destination must clear while the next must not. Long runs with random frequencies, sync bits and test pulses, checked against a behavioural model on every clock, then cover mixed cases, test-mode holds and the ring MSB.

// File: rtl/osc_sync_pkg.sv
package osc_sync_pkg;

    typedef enum logic [1:0] {
        PH_LOW  = 2'd0,
        PH_HIGH = 2'd1,
        PH_HELD = 2'd2
    } phase_e;

    // Ring wiring: voice v is synced by voice (v + n - 1) mod n
    function automatic int src_of(input int v, input int n);
        return (v + n - 1) % n;
    endfunction

endpackage

// File: rtl/osc_phase_track.sv
module osc_phase_track
    import osc_sync_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] adv_acc,
    input  logic             test,
    input  logic             clear,
    output logic [ACC_W-1:0] acc_q,
    output logic             msb_rise
);
    localparam int MSB = ACC_W - 1;

    phase_e           state_q;
    phase_e           state_d;
    logic [ACC_W-1:0] acc_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state and next accumulator
    always_comb begin
        state_d = state_q;
        acc_d   = adv_acc;
        if (test) begin
            state_d = PH_HELD;              // T_HOLD
            acc_d   = '0;
        end else if (clear) begin
            state_d = PH_LOW;               // T_SYNC
            acc_d   = '0;
        end else if (adv_acc[MSB]) begin
            state_d = PH_HIGH;              // T_RISE / T_STAY
        end else begin
            state_d = PH_LOW;               // T_WRAP
        end
    end

    // Output decode: rise only from a low or held phase
    always_comb begin
        msb_rise = 1'b0;
        unique case (state_q)
            PH_LOW,
            PH_HELD: msb_rise = !test && adv_acc[MSB];
            PH_HIGH: msb_rise = 1'b0;
            default: msb_rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/osc_sync_resolve.sv
module osc_sync_resolve
    import osc_sync_pkg::*;
#(
    parameter int NUM_VOICES = 3
) (
    input  logic [NUM_VOICES-1:0] rise,
    input  logic [NUM_VOICES-1:0] sync_en,
    output logic [NUM_VOICES-1:0] clear
);
    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_dst
        localparam int SRC  = src_of(v, NUM_VOICES);
        localparam int SRC2 = src_of(SRC, NUM_VOICES);
        logic src_blocked;
        // source that is itself synced this cycle does not pass sync on
        assign src_blocked = sync_en[SRC] && rise[SRC2];
        assign clear[v]    = rise[SRC] && sync_en[v] && !src_blocked;
    end

endmodule

// File: rtl/osc_ring_msb.sv
module osc_ring_msb
    import osc_sync_pkg::*;
#(
    parameter int NUM_VOICES = 3,
    parameter int ACC_W      = 24
) (
    input  logic [NUM_VOICES-1:0][ACC_W-1:0] acc,
    output logic [NUM_VOICES-1:0]            ring_msb
);
    localparam int MSB = ACC_W - 1;

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_ring
        localparam int SRC = src_of(v, NUM_VOICES);
        assign ring_msb[v] = acc[v][MSB] ^ acc[SRC][MSB];
    end

endmodule

// File: rtl/osc_sync_ring.sv
module osc_sync_ring
    import osc_sync_pkg::*;
#(
    parameter int NUM_VOICES = 3,
    parameter int ACC_W      = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_VOICES-1:0][ACC_W-1:0] adv_acc_i,
    input  logic [NUM_VOICES-1:0]            test_i,
    input  logic [NUM_VOICES-1:0]            sync_en_i,
    output logic [NUM_VOICES-1:0][ACC_W-1:0] acc_o,
    output logic [NUM_VOICES-1:0]            msb_rise_o,
    output logic [NUM_VOICES-1:0]            ring_msb_o
);
    logic [NUM_VOICES-1:0] rise;
    logic [NUM_VOICES-1:0] clear;

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        osc_phase_track #(.ACC_W(ACC_W)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_acc  (adv_acc_i[v]),
            .test     (test_i[v]),
            .clear    (clear[v]),
            .acc_q    (acc_o[v]),
            .msb_rise (rise[v])
        );
    end

    osc_sync_resolve #(.NUM_VOICES(NUM_VOICES)) u_resolve (
        .rise    (rise),
        .sync_en (sync_en_i),
        .clear   (clear)
    );

    osc_ring_msb #(.NUM_VOICES(NUM_VOICES), .ACC_W(ACC_W)) u_ring (
        .acc      (acc_o),
        .ring_msb (ring_msb_o)
    );

    assign msb_rise_o = rise;

endmodule

// File: rtl/osc_sync_ring_chk.sv
module osc_sync_ring_chk
    import osc_sync_pkg::*;
#(
    parameter int NUM_VOICES = 3,
    parameter int ACC_W      = 24
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_VOICES-1:0][ACC_W-1:0] adv_acc_i,
    input logic [NUM_VOICES-1:0]            test_i,
    input logic [NUM_VOICES-1:0]            sync_en_i,
    input logic [NUM_VOICES-1:0][ACC_W-1:0] acc_o,
    input logic [NUM_VOICES-1:0]            msb_rise_o
);
    localparam int MSB = ACC_W - 1;

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_chk
        localparam int S  = src_of(v, NUM_VOICES);
        localparam int SS = src_of(S, NUM_VOICES);

        // R4: test holds the accumulator at zero
        assert_test_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            test_i[v] |=> acc_o[v] == '0);

        // R4: no rise reported in test mode
        assert_test_norise_R4: assert property (@(posedge clk) disable iff (!rst_n)
            test_i[v] |-> !msb_rise_o[v]);

        // R3: a rise means low registered MSB and high advanced MSB
        assert_rise_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
            msb_rise_o[v] |-> (!acc_o[v][MSB] && adv_acc_i[v][MSB]));

        // R6: unblocked source rise with sync enabled clears destination
        assert_sync_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (msb_rise_o[S] && sync_en_i[v] && !(sync_en_i[S] && msb_rise_o[SS]))
            |=> acc_o[v] == '0);

        // R7: blocked source leaves the destination advancing
        assert_sync_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!test_i[v] && sync_en_i[S] && msb_rise_o[SS])
            |=> acc_o[v] == $past(adv_acc_i[v]));

        // R9 / R2: no sync enable, no test: plain registration
        assert_no_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!test_i[v] && !sync_en_i[v]) |=> acc_o[v] == $past(adv_acc_i[v]));
    end

endmodule

bind osc_sync_ring osc_sync_ring_chk #(
    .NUM_VOICES (NUM_VOICES),
    .ACC_W      (ACC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_acc_i  (adv_acc_i),
    .test_i     (test_i),
    .sync_en_i  (sync_en_i),
    .acc_o      (acc_o),
    .msb_rise_o (msb_rise_o)
);

// File: tb/osc_sync_ring_bench.sv
module osc_bench_voice #(
    parameter int ACC_W = 24
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] freq,
    input  logic             test,
    output logic [ACC_W-1:0] adv
);
    assign adv = test ? '0 : acc + freq;
endmodule

module osc_sync_ring_bench;
    localparam int NV = 3;
    localparam int W  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [NV-1:0][W-1:0] adv_acc;
    logic [NV-1:0][W-1:0] acc_o;
    logic [W-1:0]         freq [NV];
    logic [NV-1:0]        test_in = '0;
    logic [NV-1:0]        sync_en = '0;
    logic [NV-1:0]        rise_o;
    logic [NV-1:0]        ring_o;

    for (genvar v = 0; v < NV; v++) begin : g_v
        osc_bench_voice #(.ACC_W(W)) u_voice (
            .acc  (acc_o[v]),
            .freq (freq[v]),
            .test (test_in[v]),
            .adv  (adv_acc[v])
        );
    end

    osc_sync_ring u_osc_sync_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_acc_i  (adv_acc),
        .test_i     (test_in),
        .sync_en_i  (sync_en),
        .acc_o      (acc_o),
        .msb_rise_o (rise_o),
        .ring_msb_o (ring_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] m_acc [NV];

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int src(input int v);
        return (v + 2) % 3;   // R5 wiring
    endfunction

    // One clock: check rise, advance model, check registered outputs
    task automatic run_cycle();
        logic [W-1:0] m_adv [NV];
        bit           m_rise [NV];
        bit           clr;
        #2;
        for (int v = 0; v < NV; v++) begin
            m_adv[v]  = test_in[v] ? '0 : m_acc[v] + freq[v];
            m_rise[v] = !test_in[v] && !m_acc[v][W-1] && m_adv[v][W-1];
            check(rise_o[v] == m_rise[v], "R3", {23'd0, rise_o[v]}, {23'd0, m_rise[v]});
        end
        for (int v = 0; v < NV; v++) begin
            clr = m_rise[src(v)] && sync_en[v] && !(sync_en[src(v)] && m_rise[src(src(v))]);
            if (test_in[v] || clr) m_acc[v] = '0;
            else                   m_acc[v] = m_adv[v];
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        for (int v = 0; v < NV; v++) begin
            bit er;
            check(acc_o[v] == m_acc[v], "R2/R6/R7", acc_o[v], m_acc[v]);
            er = m_acc[v][W-1] ^ m_acc[src(v)][W-1];
            check(ring_o[v] == er, "R8", {23'd0, ring_o[v]}, {23'd0, er});
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            freq[v]  = '0;
            m_acc[v] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int v = 0; v < NV; v++) begin
            check(acc_o[v] == '0, "R1", acc_o[v], '0);
            check(ring_o[v] == 1'b0 && rise_o[v] == 1'b0, "R1",
                  {22'd0, ring_o[v], rise_o[v]}, '0);
        end

        // Pattern A: free running, no sync (R2, R3, R9)
        freq[0] = 24'h012345; freq[1] = 24'h0A0000; freq[2] = 24'h200001;
        repeat (300) run_cycle();

        // Pattern B: voice 1 synced by voice 0 (R5, R6)
        sync_en = 3'b010;
        freq[0] = 24'h100000; freq[1] = 24'h030001; freq[2] = 24'h000123;
        repeat (120) run_cycle();

        // Pattern C: same-cycle exception (R7)
        test_in = 3'b111;
        repeat (2) run_cycle();
        test_in = 3'b000;
        sync_en = 3'b011;
        freq[0] = 24'h100000; freq[1] = 24'h010000; freq[2] = 24'h100000;
        repeat (8) run_cycle();
        check(acc_o[0] == '0, "R5", acc_o[0], '0);            // v0 cleared by v2
        check(acc_o[1] == 24'h080000, "R7", acc_o[1], 24'h080000);
        check(acc_o[2] == 24'h800000, "R9", acc_o[2], 24'h800000);
        repeat (40) run_cycle();

        // Pattern D: test mode on one voice (R4)
        test_in = 3'b100;
        freq[2] = 24'h7FFFFF;
        repeat (20) run_cycle();
        check(acc_o[2] == '0, "R4", acc_o[2], '0);
        check(rise_o[2] == 1'b0, "R4", {23'd0, rise_o[2]}, '0);
        test_in = 3'b000;
        repeat (20) run_cycle();

        // Pattern E: random mixes
        for (int blk = 0; blk < 40; blk++) begin
            for (int v = 0; v < NV; v++) freq[v] = W'($urandom_range(24'h3FFFFF, 1));
            sync_en = NV'($urandom);
            test_in = (blk % 7 == 3) ? NV'($urandom) : '0;
            repeat (60) run_cycle();
        end

        finish_run();
    end

endmodule